// File: doc/BRIEF.md
# Serial Clock-Synthesizer Configuration Loader

This block collects the setup word for a programmable clock synthesizer when that word is delivered one bit per register write. Each accepted write carries a single configuration bit. A second flag in the same write marks the bit that closes the frame. The block shifts the bits into a fixed 56-bit frame image. When the closing bit arrives, it checks the fixed parts of the frame and decodes the variable parts in the same cycle: the post-divider select, the frequency band and the three divider values.

If the frame has the right length, its fixed fields match and its codes are legal, the decoded values are latched and a single-cycle load strobe tells the downstream clock-generation model to take them. Any other commit raises an error flag, leaves the latched values as they were and produces no strobe. Every commit, good or bad, rewinds the bit counter so the next frame starts clean.

Top module: `synth_cfg_loader`

## Requirements
- R1: A write counts only while `wr_en` is high. `wr_data[0]` is the configuration bit and `wr_data[1]` set marks the final bit of the frame. Cycles with `wr_en` low change nothing, whatever `wr_data` holds.
- R2: A commit at exactly 56 bits whose fixed fields and codes are valid makes `load_o` high for exactly one cycle, the cycle after the commit write. In that same cycle all field outputs take the new values.
- R3: Arrival positions 12 and 13 carry the post-divider code, least significant bit first. `post_div_o` gives the code, so 0, 1 and 2 mean divide by 1, 2 and 4.
- R4: Arrival positions 24 and 25 carry the band bits. First 0 and second 0 gives `band_o`=0 (up to 120 MHz). First 1 and second 0 gives 1 (up to 200 MHz). First 0 and second 1 gives 2 (above 200 MHz).
- R5: M occupies positions 32..39, A occupies 40..47 and R occupies 48..55, each least significant bit first. `m_o` and `a_o` show the received values. `r_o` is 9 bits wide and shows the received R plus one.
- R6: A commit at any bit count other than 56 sets `frame_err_o`, gives no `load_o` pulse and leaves every field output unchanged.
- R7: The frame has three fixed parts, and a mismatch in any of them is handled as in R6:
  - positions 0..11 must be a 1 followed by eleven 0s;
  - positions 14..23 must all be 0;
  - positions 26..31 must be 1,0,0,1,0,1 in arrival order.
- R8: An M value above 0x3F, a post-divider code of 3 or a band pair of first 1 and second 1 is handled as in R6.
- R9: After any commit the bit count restarts at zero. `frame_err_o` keeps its value until the next commit, and a good commit clears it.
- R10: After reset, `load_o` and `frame_err_o` are 0 and every field output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write valid |
| wr_data | input | 2 | Bit 0: configuration bit; bit 1: final-bit marker |
| load_o | output | 1 | One-cycle strobe when new settings are applied |
| frame_err_o | output | 1 | Last commit was rejected |
| post_div_o | output | 2 | Post-divider code (0: /1, 1: /2, 2: /4) |
| band_o | output | 2 | Frequency band (0 low, 1 mid, 2 high) |
| m_o | output | 8 | M divider value |
| a_o | output | 8 | A divider value |
| r_o | output | 9 | R divider value (received field plus one) |

## Verification
The good frames use distinct values in every field, so a field placed at the wrong arrival position or a bit order reversed shows up as a wrong value. One of them pushes M to its 0x3F limit and A and R to all ones, which catches a lost carry in the R+1 output. One good frame is sent with idle cycles between its writes, and those idle cycles carry a set final-bit marker, to show that unqualified writes are ignored. Frames one bit short and one bit long test the length check. Single flipped bits in the preamble, the zero gap and the fixed pattern test each fixed-field comparison. Illegal M, post-divider and band codes test the code checks, and a good frame after each rejection shows that the counter has restarted and the error flag has cleared.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Field widths of the serial frame (arrival order)
  localparam int PRE_LEN    = 12;
  localparam int DIVSEL_LEN = 2;
  localparam int GAP_LEN    = 10;
  localparam int BAND_LEN   = 2;
  localparam int PAT_LEN    = 6;
  localparam int DIV_W      = 8;

  // Arrival positions derived from the widths
  localparam int PRE_POS    = 0;
  localparam int DIVSEL_POS = PRE_POS + PRE_LEN;
  localparam int GAP_POS    = DIVSEL_POS + DIVSEL_LEN;
  localparam int BAND_POS   = GAP_POS + GAP_LEN;
  localparam int PAT_POS    = BAND_POS + BAND_LEN;
  localparam int M_POS      = PAT_POS + PAT_LEN;
  localparam int A_POS      = M_POS + DIV_W;
  localparam int R_POS      = A_POS + DIV_W;
  localparam int FRAME_LEN  = R_POS + DIV_W;
  localparam int CNT_W      = $clog2(FRAME_LEN + 1);

  // Fixed contents; bit 0 is the earliest bit to arrive
  localparam logic [PRE_LEN-1:0] PRE_WORD = PRE_LEN'(1);
  localparam logic [PAT_LEN-1:0] PAT_WORD = 6'b101001;
  localparam logic [DIV_W-1:0]   M_MAX    = 8'h3F;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2
  } band_e;

  // raw[0] is the first band bit to arrive
  function automatic logic band_legal(input logic [BAND_LEN-1:0] raw);
    return raw != 2'b11;
  endfunction

  function automatic band_e band_decode(input logic [BAND_LEN-1:0] raw);
    case (raw)
      2'b01:   return BAND_MID;
      2'b10:   return BAND_HIGH;
      default: return BAND_LOW;
    endcase
  endfunction

  function automatic logic div_code_legal(input logic [DIVSEL_LEN-1:0] code);
    return code != 2'd3;
  endfunction

  // Transmitted R is the divider minus one
  function automatic logic [DIV_W:0] r_restore(input logic [DIV_W-1:0] raw);
    return {1'b0, raw} + (DIV_W + 1)'(1);
  endfunction

endpackage

// File: rtl/synth_cfg_shifter.sv
module synth_cfg_shifter
  import synth_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic                 bit_val,
  input  logic                 bit_last,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic                 len_ok_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-2:0] sr_q;
  logic [CNT_W-1:0]     cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (bit_valid) begin
      sr_q <= {bit_val, sr_q[FRAME_LEN-2:1]};
      if (bit_last)
        cnt_q <= '0;
      else if (cnt_q != CNT_FULL)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // Present frame as it would stand with the current bit included
  assign frame_o  = {bit_val, sr_q};
  assign len_ok_o = (cnt_q == CNT_LAST);

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_last) |=> (cnt_q == '0));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(cnt_q) && $stable(sr_q)));

endmodule

// File: rtl/synth_cfg_decoder.sv
module synth_cfg_decoder
  import synth_cfg_pkg::*;
(
  input  logic [FRAME_LEN-1:0]  frame_i,
  output logic                  fields_ok_o,
  output logic [DIVSEL_LEN-1:0] div_o,
  output logic [BAND_LEN-1:0]   band_o,
  output logic [DIV_W-1:0]      m_o,
  output logic [DIV_W-1:0]      a_o,
  output logic [DIV_W:0]        r_o
);

  logic pre_ok, gap_ok, pat_ok, code_ok;
  logic [BAND_LEN-1:0] band_raw;
  band_e band_dec;

  assign pre_ok   = frame_i[PRE_POS +: PRE_LEN] == PRE_WORD;
  assign gap_ok   = frame_i[GAP_POS +: GAP_LEN] == '0;
  assign pat_ok   = frame_i[PAT_POS +: PAT_LEN] == PAT_WORD;

  assign div_o    = frame_i[DIVSEL_POS +: DIVSEL_LEN];
  assign band_raw = frame_i[BAND_POS +: BAND_LEN];
  assign band_dec = band_decode(band_raw);
  assign band_o   = band_dec;
  assign m_o      = frame_i[M_POS +: DIV_W];
  assign a_o      = frame_i[A_POS +: DIV_W];
  assign r_o      = r_restore(frame_i[R_POS +: DIV_W]);

  assign code_ok  = div_code_legal(div_o) && band_legal(band_raw) && (m_o <= M_MAX);
  assign fields_ok_o = pre_ok && gap_ok && pat_ok && code_ok;

endmodule

// File: rtl/synth_cfg_latch.sv
module synth_cfg_latch
  import synth_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_i,
  input  logic                  good_i,
  input  logic [DIVSEL_LEN-1:0] div_i,
  input  logic [BAND_LEN-1:0]   band_i,
  input  logic [DIV_W-1:0]      m_i,
  input  logic [DIV_W-1:0]      a_i,
  input  logic [DIV_W:0]        r_i,
  output logic                  load_o,
  output logic                  err_o,
  output logic [DIVSEL_LEN-1:0] div_o,
  output logic [BAND_LEN-1:0]   band_o,
  output logic [DIV_W-1:0]      m_o,
  output logic [DIV_W-1:0]      a_o,
  output logic [DIV_W:0]        r_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_o <= 1'b0;
      err_o  <= 1'b0;
      div_o  <= '0;
      band_o <= '0;
      m_o    <= '0;
      a_o    <= '0;
      r_o    <= '0;
    end else begin
      load_o <= commit_i && good_i;
      if (commit_i) begin
        err_o <= !good_i;
        if (good_i) begin
          div_o  <= div_i;
          band_o <= band_i;
          m_o    <= m_i;
          a_o    <= a_i;
          r_o    <= r_i;
        end
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  a_r6_no_err_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> !err_o);

  a_r6_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |-> ($stable(m_o) && $stable(a_o) && $stable(r_o)
                 && $stable(div_o) && $stable(band_o)));

  a_r8_m_limit: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (m_o <= M_MAX));

  a_r3_div_code: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (div_o != 2'd3));

  a_r4_band_code: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (band_o != 2'd3));

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_data,
  output logic         load_o,
  output logic         frame_err_o,
  output logic [1:0]   post_div_o,
  output logic [1:0]   band_o,
  output logic [7:0]   m_o,
  output logic [7:0]   a_o,
  output logic [8:0]   r_o
);

  logic [FRAME_LEN-1:0]  frame_w;
  logic                  len_ok_w;
  logic                  fields_ok_w;
  logic                  commit_w;
  logic                  good_w;
  logic [DIVSEL_LEN-1:0] dec_div_w;
  logic [BAND_LEN-1:0]   dec_band_w;
  logic [DIV_W-1:0]      dec_m_w, dec_a_w;
  logic [DIV_W:0]        dec_r_w;

  assign commit_w = wr_en && wr_data[1];
  assign good_w   = len_ok_w && fields_ok_w;

  synth_cfg_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (wr_en),
    .bit_val   (wr_data[0]),
    .bit_last  (wr_data[1]),
    .frame_o   (frame_w),
    .len_ok_o  (len_ok_w)
  );

  synth_cfg_decoder u_dec (
    .frame_i     (frame_w),
    .fields_ok_o (fields_ok_w),
    .div_o       (dec_div_w),
    .band_o      (dec_band_w),
    .m_o         (dec_m_w),
    .a_o         (dec_a_w),
    .r_o         (dec_r_w)
  );

  synth_cfg_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit_w),
    .good_i   (good_w),
    .div_i    (dec_div_w),
    .band_i   (dec_band_w),
    .m_i      (dec_m_w),
    .a_i      (dec_a_w),
    .r_i      (dec_r_w),
    .load_o   (load_o),
    .err_o    (frame_err_o),
    .div_o    (post_div_o),
    .band_o   (band_o),
    .m_o      (m_o),
    .a_o      (a_o),
    .r_o      (r_o)
  );

  a_r2_load_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $past(commit_w));

  a_r6_err_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err_o) |-> $past(commit_w));

endmodule

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic       load_o, frame_err_o;
  logic [1:0] post_div_o, band_o;
  logic [7:0] m_o, a_o;
  logic [8:0] r_o;

  int n_checks = 0;
  int n_fail   = 0;

  int exp_div = 0, exp_band = 0, exp_m = 0, exp_a = 0, exp_r = 0;

  always #4 clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .load_o(load_o), .frame_err_o(frame_err_o), .post_div_o(post_div_o),
    .band_o(band_o), .m_o(m_o), .a_o(a_o), .r_o(r_o)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Frame image, index = arrival order, built from the field list
  function automatic logic [63:0] mk(input int dsel, input int b_first, input int b_second,
                                     input int m, input int a, input int r, input int flip);
    logic [63:0] f;
    int p;
    f = '0;
    p = 0;
    f[p] = 1'b1;                 p += 12;   // preamble: 1 then zeros
    f[p] = dsel[0]; f[p+1] = dsel[1]; p += 2;
    p += 10;                                // zero gap
    f[p] = b_first[0]; f[p+1] = b_second[0]; p += 2;
    f[p] = 1'b1; f[p+3] = 1'b1; f[p+5] = 1'b1; p += 6; // 1,0,0,1,0,1
    for (int i = 0; i < 8; i++) f[p+i] = m[i];
    p += 8;
    for (int i = 0; i < 8; i++) f[p+i] = a[i];
    p += 8;
    for (int i = 0; i < 8; i++) f[p+i] = r[i];
    if (flip >= 0) f[flip] = ~f[flip];
    return f;
  endfunction

  // Sends n bits; idle cycles between writes carry a set marker with wr_en low
  task automatic send(input logic [63:0] f, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = {(i == n - 1), f[i]};
      if (gap > 0 && i != n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          wr_en   = 1'b0;
          wr_data = 2'b11;
        end
      end
    end
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 2'b00;
  endtask

  task automatic check_fields(input string tag);
    check_eq({tag, " R3 post_div"}, int'(post_div_o), exp_div);
    check_eq({tag, " R4 band"},     int'(band_o),     exp_band);
    check_eq({tag, " R5 m"},        int'(m_o),        exp_m);
    check_eq({tag, " R5 a"},        int'(a_o),        exp_a);
    check_eq({tag, " R5 r"},        int'(r_o),        exp_r);
  endtask

  task automatic good_frame(input string tag, input int dsel, input int bf, input int bs,
                            input int m, input int a, input int r, input int gap);
    send(mk(dsel, bf, bs, m, a, r, -1), 56, gap);
    exp_div  = dsel;
    exp_band = (bf == 1) ? 1 : ((bs == 1) ? 2 : 0);
    exp_m    = m;
    exp_a    = a;
    exp_r    = r + 1;
    check_eq({tag, " R2 load"}, int'(load_o), 1);
    check_eq({tag, " R9 err clear"}, int'(frame_err_o), 0);
    check_fields(tag);
    @(negedge clk);
    check_eq({tag, " R2 single pulse"}, int'(load_o), 0);
  endtask

  task automatic bad_frame(input string tag, input logic [63:0] f, input int n);
    send(f, n, 0);
    check_eq({tag, " R6 no load"}, int'(load_o), 0);
    check_eq({tag, " R6 err"}, int'(frame_err_o), 1);
    check_fields({tag, " R6 hold"});
    @(negedge clk);
    check_eq({tag, " R9 err held"}, int'(frame_err_o), 1);
    check_eq({tag, " R6 still no load"}, int'(load_o), 0);
  endtask

  task automatic t_reset;
    check_eq("R10 load", int'(load_o), 0);
    check_eq("R10 err", int'(frame_err_o), 0);
    check_fields("R10");
  endtask

  task automatic t_basic;   good_frame("basic", 0, 0, 0, 8'h22, 8'h01, 8'h1D, 0); endtask
  task automatic t_edges;   good_frame("edges", 2, 0, 1, 8'h3F, 8'hFF, 8'hFF, 0); endtask
  task automatic t_gaps;    good_frame("R1 gaps", 1, 1, 0, 8'h05, 8'h80, 8'h00, 2); endtask
  task automatic t_short;   bad_frame("short R6", mk(1, 1, 0, 8'h11, 8'h22, 8'h33, -1), 55); endtask
  task automatic t_long;    bad_frame("long R6", mk(1, 1, 0, 8'h11, 8'h22, 8'h33, -1), 57); endtask
  task automatic t_pre;     bad_frame("preamble R7", mk(0, 0, 0, 8'h10, 8'h10, 8'h10, 0), 56); endtask
  task automatic t_pre2;    bad_frame("preamble2 R7", mk(0, 0, 0, 8'h10, 8'h10, 8'h10, 7), 56); endtask
  task automatic t_zgap;    bad_frame("gap R7", mk(0, 0, 0, 8'h10, 8'h10, 8'h10, 20), 56); endtask
  task automatic t_pat;     bad_frame("pattern R7", mk(0, 0, 0, 8'h10, 8'h10, 8'h10, 28), 56); endtask
  task automatic t_mlim;    bad_frame("m limit R8", mk(0, 0, 0, 8'h40, 8'h10, 8'h10, -1), 56); endtask
  task automatic t_dcode;   bad_frame("div code R8", mk(3, 0, 0, 8'h10, 8'h10, 8'h10, -1), 56); endtask
  task automatic t_bcode;   bad_frame("band code R8", mk(0, 1, 1, 8'h10, 8'h10, 8'h10, -1), 56); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_edges();
    t_gaps();
    t_short();
    good_frame("recover R9", 0, 1, 0, 8'h2A, 8'h03, 8'h07, 0);
    t_long();
    t_basic();
    t_pre();
    t_pre2();
    t_zgap();
    t_pat();
    t_mlim();
    t_dcode();
    t_bcode();
    good_frame("final R9", 2, 0, 0, 8'h01, 8'h00, 8'h80, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule